// File: doc/BRIEF.md
# Power domain on/off sequencer

This block brings one switchable logic domain up or down on request, one control action per clock cycle. It owns a seven-bit control word that drives the domain's two power switches, its isolation cells, its clock gate, its reset and two SRAM isolation controls. Two acknowledge inputs from the switch fabric report whether power has actually arrived. The SRAM power handshake and the bus-protection handshake live in neighbouring blocks. This sequencer reaches them through a one-cycle start pulse with a direction bit, and it waits for a one-cycle done pulse in return.

Every wait is bounded by a timeout counted in clock cycles. If power-up fails after power has been applied, the steps already taken are walked back in reverse order before the error is reported. A power-down that fails stops where it is. Two straps shape the sequence. One selects strict bus-protection ordering, which moves the subsystem-clock enable. The other enables the SRAM isolation steps.

Top module: `pwr_dom_seq`

## Requirements
- R1: After reset the control word is 7'h32, meaning isolation (bit 1), clock disable (bit 4) and SRAM clock isolation (bit 5) are set, while reset release (bit 0), primary switch (bit 2), secondary switch (bit 3) and SRAM isolation release (bit 6, active low) are clear. Also after reset, busy, done, err and subsys_clk_en are low.
- R2: dom_on is high only when ack_pri and ack_sec are both high. One acknowledge alone never satisfies a power-up wait.
- R3: Power-up performs these steps in order: set bit 2; set bit 3; wait for dom_on; clear bit 4; clear bit 1; set bit 0.
- R4: After reset release, power-up pulses sram_start with sram_en=1 and waits for sram_done. When sram_iso_en is high it then sets bit 6 and afterwards clears bit 5. Next it pulses bp_start with bp_apply=0 (release) and waits for bp_done. It ends with a done pulse and err low.
- R5: With strict_mode low, subsys_clk_en rises right after reset release and before sram_start. With strict_mode high, it rises only after bp_done for the release.
- R6: Power-down performs these steps in order: bp_start with bp_apply=1 and wait; when sram_iso_en is high, set bit 5 and then clear bit 6; sram_start with sram_en=0 and wait; drop subsys_clk_en; set bit 1; set bit 4; clear bit 0; clear bit 3; clear bit 2; wait until dom_on is low; done pulse.
- R7: Each wait ends with a timeout if its condition has not arrived within TIMEOUT+1 cycles of entering the wait. A timeout ends the operation with done and err both high.
- R8: A power-up timeout unwinds in reverse order before done. If the bus release timed out, the unwind re-applies bus protection, undoes the SRAM isolation steps and disables the SRAM. In every case the unwind then drops subsys_clk_en, sets bit 1, sets bit 4, clears bit 0, clears bit 3 and clears bit 2. Timeouts during the unwind are passed over. After a failed power-up the domain counts as off.
- R9: A power-down timeout on the bus or SRAM handshake stops at once with err, leaves the rest of the control word untouched, and keeps the domain counted as on. A timeout on the final acknowledge wait leaves the domain counted as off.
- R10: on_req and off_req are ignored while busy is high. They neither change nor extend the running sequence.
- R11: A request for the state the domain is already counted in produces done in the following cycle with err low and no control change. If both requests are high together, on_req wins.
- R12: done is a single-cycle pulse raised while busy is low. busy stays high from the cycle after a request is accepted until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_req | input | 1 | Request power-up (sampled when idle) |
| off_req | input | 1 | Request power-down (sampled when idle) |
| strict_mode | input | 1 | Strap: subsystem clock enabled only after bus release |
| sram_iso_en | input | 1 | Strap: perform the SRAM isolation steps |
| ack_pri | input | 1 | Primary power-switch acknowledge |
| ack_sec | input | 1 | Secondary power-switch acknowledge |
| sram_done | input | 1 | SRAM handshake completion pulse |
| bp_done | input | 1 | Bus-protection handshake completion pulse |
| ctl | output | 7 | Domain control word |
| subsys_clk_en | output | 1 | Subsystem clock enable |
| sram_start | output | 1 | SRAM handshake start pulse |
| sram_en | output | 1 | SRAM direction with sram_start: 1 enable, 0 disable |
| bp_start | output | 1 | Bus-protection handshake start pulse |
| bp_apply | output | 1 | Bus direction with bp_start: 1 apply, 0 release |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last operation failed; held until the next accepted request |
| dom_on | output | 1 | Both acknowledges are asserted |

## Verification
The bench logs every control-bit change and every handshake pulse. It compares that log with an order predicted from the straps, the fault and the tracked domain state, so a design that swapped two steps or skipped one is caught even when the final word is correct.

The faults it injects are these:
- A secondary acknowledge held low while the primary rises. An OR of the acknowledges would then complete power-up.
- A stuck SRAM responder and a stuck bus responder, in either direction. A design that missed part of the reverse unwind, or unwound after a power-down failure, would show stray or missing events.
- Acknowledges held high at power-down. A missing timeout would hang here.

Requests pulsed during a running sequence and requests for the current state check that nothing restarts. They also check that the immediate done lands exactly one cycle later.

// File: rtl/pwr_dom_pkg.sv
package pwr_dom_pkg;

   localparam int CTL_W    = 7;
   localparam int BIT_RSTB = 0;
   localparam int BIT_ISO  = 1;
   localparam int BIT_PRI  = 2;
   localparam int BIT_SEC  = 3;
   localparam int BIT_CKD  = 4;
   localparam int BIT_SCKI = 5;
   localparam int BIT_SISB = 6;

   localparam logic [CTL_W-1:0] CTL_RESET = 7'b0110010;

   typedef enum logic [4:0] {
      S_IDLE,
      S_PU_PRI, S_PU_SEC, S_PU_ACK, S_PU_CKD, S_PU_ISO, S_PU_RST,
      S_PU_SCKN, S_PU_SRGO, S_PU_SRW, S_PU_SI1, S_PU_SI2,
      S_PU_BPGO, S_PU_BPW, S_PU_SCKS,
      S_PD_BPGO, S_PD_BPW, S_PD_SI1, S_PD_SI2, S_PD_SRGO, S_PD_SRW,
      S_PD_SCK, S_PD_ISO, S_PD_CKD, S_PD_RST, S_PD_SEC, S_PD_PRI, S_PD_ACK
   } seq_state_t;

endpackage

// File: rtl/pwr_dom_ack.sv
module pwr_dom_ack #(
   parameter int SYNC_STG = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_pri,
   input  logic ack_sec,
   output logic both_on
);
   logic pri_s, sec_s;

   generate
      if (SYNC_STG == 0) begin : g_direct
         assign pri_s = ack_pri;
         assign sec_s = ack_sec;
      end else begin : g_sync
         logic [SYNC_STG-1:0] pri_q, sec_q;
         if (SYNC_STG == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  pri_q <= '0;
                  sec_q <= '0;
               end else begin
                  pri_q <= ack_pri;
                  sec_q <= ack_sec;
               end
            end
         end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  pri_q <= '0;
                  sec_q <= '0;
               end else begin
                  pri_q <= {pri_q[SYNC_STG-2:0], ack_pri};
                  sec_q <= {sec_q[SYNC_STG-2:0], ack_sec};
               end
            end
         end
         assign pri_s = pri_q[SYNC_STG-1];
         assign sec_s = sec_q[SYNC_STG-1];
      end
   endgenerate

   assign both_on = pri_s & sec_s;
endmodule

// File: rtl/pwr_dom_tmr.sv
module pwr_dom_tmr #(
   parameter int TIMEOUT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic expired
);
   localparam int TW = $clog2(TIMEOUT + 1);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (clr)      cnt <= '0;
      else if (!expired) cnt <= cnt + 1'b1;
   end

   assign expired = (cnt == TW'(TIMEOUT));
endmodule

// File: rtl/pwr_dom_fsm.sv
module pwr_dom_fsm
   import pwr_dom_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             on_req,
   input  logic             off_req,
   input  logic             strict_mode,
   input  logic             sram_iso_en,
   input  logic             dom_on,
   input  logic             tmr_exp,
   input  logic             sram_done,
   input  logic             bp_done,
   output logic [CTL_W-1:0] ctl,
   output logic             subsys_clk_en,
   output logic             sram_start,
   output logic             sram_en,
   output logic             bp_start,
   output logic             bp_apply,
   output logic             busy,
   output logic             done,
   output logic             err,
   output logic             tmr_clr
);
   seq_state_t       st;
   logic [CTL_W-1:0] ctl_q;
   logic             sclk_q, up_q, unw_q, done_q, err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         ctl_q  <= CTL_RESET;
         sclk_q <= 1'b0;
         up_q   <= 1'b0;
         unw_q  <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st)
            S_IDLE: begin
               if (on_req) begin
                  err_q <= 1'b0;
                  if (up_q) done_q <= 1'b1;
                  else      st     <= S_PU_PRI;
               end else if (off_req) begin
                  err_q <= 1'b0;
                  if (!up_q) done_q <= 1'b1;
                  else       st     <= S_PD_BPGO;
               end
            end
            S_PU_PRI: begin ctl_q[BIT_PRI] <= 1'b1; st <= S_PU_SEC; end
            S_PU_SEC: begin ctl_q[BIT_SEC] <= 1'b1; st <= S_PU_ACK; end
            S_PU_ACK: begin
               if (dom_on)       st <= S_PU_CKD;
               else if (tmr_exp) begin unw_q <= 1'b1; st <= S_PD_SCK; end
            end
            S_PU_CKD: begin ctl_q[BIT_CKD] <= 1'b0; st <= S_PU_ISO; end
            S_PU_ISO: begin ctl_q[BIT_ISO] <= 1'b0; st <= S_PU_RST; end
            S_PU_RST: begin
               ctl_q[BIT_RSTB] <= 1'b1;
               st <= strict_mode ? S_PU_SRGO : S_PU_SCKN;
            end
            S_PU_SCKN: begin sclk_q <= 1'b1; st <= S_PU_SRGO; end
            S_PU_SRGO: st <= S_PU_SRW;
            S_PU_SRW: begin
               if (sram_done)    st <= sram_iso_en ? S_PU_SI1 : S_PU_BPGO;
               else if (tmr_exp) begin unw_q <= 1'b1; st <= S_PD_SCK; end
            end
            S_PU_SI1: begin ctl_q[BIT_SISB] <= 1'b1; st <= S_PU_SI2; end
            S_PU_SI2: begin ctl_q[BIT_SCKI] <= 1'b0; st <= S_PU_BPGO; end
            S_PU_BPGO: st <= S_PU_BPW;
            S_PU_BPW: begin
               if (bp_done) begin
                  if (strict_mode) st <= S_PU_SCKS;
                  else begin
                     up_q <= 1'b1; done_q <= 1'b1; st <= S_IDLE;
                  end
               end else if (tmr_exp) begin
                  unw_q <= 1'b1; st <= S_PD_BPGO;
               end
            end
            S_PU_SCKS: begin
               sclk_q <= 1'b1; up_q <= 1'b1; done_q <= 1'b1; st <= S_IDLE;
            end
            S_PD_BPGO: st <= S_PD_BPW;
            S_PD_BPW: begin
               if (bp_done || (tmr_exp && unw_q))
                  st <= sram_iso_en ? S_PD_SI1 : S_PD_SRGO;
               else if (tmr_exp) begin
                  err_q <= 1'b1; done_q <= 1'b1; st <= S_IDLE;
               end
            end
            S_PD_SI1: begin ctl_q[BIT_SCKI] <= 1'b1; st <= S_PD_SI2; end
            S_PD_SI2: begin ctl_q[BIT_SISB] <= 1'b0; st <= S_PD_SRGO; end
            S_PD_SRGO: st <= S_PD_SRW;
            S_PD_SRW: begin
               if (sram_done || (tmr_exp && unw_q)) st <= S_PD_SCK;
               else if (tmr_exp) begin
                  err_q <= 1'b1; done_q <= 1'b1; st <= S_IDLE;
               end
            end
            S_PD_SCK: begin sclk_q <= 1'b0; up_q <= 1'b0; st <= S_PD_ISO; end
            S_PD_ISO: begin ctl_q[BIT_ISO]  <= 1'b1; st <= S_PD_CKD; end
            S_PD_CKD: begin ctl_q[BIT_CKD]  <= 1'b1; st <= S_PD_RST; end
            S_PD_RST: begin ctl_q[BIT_RSTB] <= 1'b0; st <= S_PD_SEC; end
            S_PD_SEC: begin ctl_q[BIT_SEC]  <= 1'b0; st <= S_PD_PRI; end
            S_PD_PRI: begin
               ctl_q[BIT_PRI] <= 1'b0;
               if (unw_q) begin
                  unw_q <= 1'b0; err_q <= 1'b1; done_q <= 1'b1; st <= S_IDLE;
               end else begin
                  st <= S_PD_ACK;
               end
            end
            S_PD_ACK: begin
               if (!dom_on) begin
                  done_q <= 1'b1; st <= S_IDLE;
               end else if (tmr_exp) begin
                  err_q <= 1'b1; done_q <= 1'b1; st <= S_IDLE;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign tmr_clr = !(st inside {S_PU_ACK, S_PU_SRW, S_PU_BPW,
                                 S_PD_BPW, S_PD_SRW, S_PD_ACK});

   assign ctl           = ctl_q;
   assign subsys_clk_en = sclk_q;
   assign sram_start    = (st == S_PU_SRGO) || (st == S_PD_SRGO);
   assign sram_en       = (st == S_PU_SRGO);
   assign bp_start      = (st == S_PU_BPGO) || (st == S_PD_BPGO);
   assign bp_apply      = (st == S_PD_BPGO);
   assign busy          = (st != S_IDLE);
   assign done          = done_q;
   assign err           = err_q;
endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
   import pwr_dom_pkg::*;
#(
   parameter int TIMEOUT  = 64,
   parameter int SYNC_STG = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             on_req,
   input  logic             off_req,
   input  logic             strict_mode,
   input  logic             sram_iso_en,
   input  logic             ack_pri,
   input  logic             ack_sec,
   input  logic             sram_done,
   input  logic             bp_done,
   output logic [CTL_W-1:0] ctl,
   output logic             subsys_clk_en,
   output logic             sram_start,
   output logic             sram_en,
   output logic             bp_start,
   output logic             bp_apply,
   output logic             busy,
   output logic             done,
   output logic             err,
   output logic             dom_on
);
   generate
      if (TIMEOUT < 2) begin : g_bad_timeout
         $error("pwr_dom_seq: TIMEOUT must be at least 2");
      end
      if (SYNC_STG < 0 || SYNC_STG > 4) begin : g_bad_sync
         $error("pwr_dom_seq: SYNC_STG must be within 0..4");
      end
   endgenerate

   logic tmr_clr, tmr_exp;

   pwr_dom_ack #(.SYNC_STG(SYNC_STG)) u_ack (
      .clk     (clk),
      .rst_n   (rst_n),
      .ack_pri (ack_pri),
      .ack_sec (ack_sec),
      .both_on (dom_on)
   );

   pwr_dom_tmr #(.TIMEOUT(TIMEOUT)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tmr_clr),
      .expired (tmr_exp)
   );

   pwr_dom_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .on_req        (on_req),
      .off_req       (off_req),
      .strict_mode   (strict_mode),
      .sram_iso_en   (sram_iso_en),
      .dom_on        (dom_on),
      .tmr_exp       (tmr_exp),
      .sram_done     (sram_done),
      .bp_done       (bp_done),
      .ctl           (ctl),
      .subsys_clk_en (subsys_clk_en),
      .sram_start    (sram_start),
      .sram_en       (sram_en),
      .bp_start      (bp_start),
      .bp_apply      (bp_apply),
      .busy          (busy),
      .done          (done),
      .err           (err),
      .tmr_clr       (tmr_clr)
   );
endmodule

// File: rtl/pwr_dom_seq_chk.sv
module pwr_dom_seq_chk
   import pwr_dom_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic [CTL_W-1:0] ctl,
   input logic             subsys_clk_en,
   input logic             sram_start,
   input logic             bp_start,
   input logic             busy,
   input logic             done,
   input logic             err
);
   // R1: reset value of the control word and status
   assert_reset_word_R1: assert property (@(posedge clk)
      !rst_n |=> (ctl == CTL_RESET && !busy && !done && !subsys_clk_en));

   assert_sec_after_pri_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl[BIT_SEC]) |-> ctl[BIT_PRI]);

   assert_rst_release_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl[BIT_RSTB]) |-> (!ctl[BIT_ISO] && !ctl[BIT_CKD]));

   assert_sram_live_domain_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sram_start |-> (ctl[BIT_RSTB] && !ctl[BIT_ISO]));

   assert_single_handshake_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(sram_start && bp_start));

   assert_sclk_after_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(subsys_clk_en) |-> ctl[BIT_RSTB]);

   assert_pri_off_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl[BIT_PRI]) |-> !ctl[BIT_SEC]);

   assert_reset_under_iso_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl[BIT_RSTB]) |-> (ctl[BIT_ISO] && ctl[BIT_CKD]));

   assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> done);

   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind pwr_dom_seq pwr_dom_seq_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ctl           (ctl),
   .subsys_clk_en (subsys_clk_en),
   .sram_start    (sram_start),
   .bp_start      (bp_start),
   .busy          (busy),
   .done          (done),
   .err           (err)
);

// File: tb/pwr_dom_seq_test.sv
module pwr_dom_seq_test;
   localparam int TO = 24;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       on_req = 1'b0, off_req = 1'b0;
   logic       strict_mode = 1'b0, sram_iso_en = 1'b0;
   logic       ack_pri, ack_sec, sram_done, bp_done;
   logic [6:0] ctl;
   logic       subsys_clk_en, sram_start, sram_en, bp_start, bp_apply;
   logic       busy, done, err, dom_on;

   pwr_dom_seq #(.TIMEOUT(TO), .SYNC_STG(0)) uut (
      .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req),
      .strict_mode(strict_mode), .sram_iso_en(sram_iso_en),
      .ack_pri(ack_pri), .ack_sec(ack_sec), .sram_done(sram_done), .bp_done(bp_done),
      .ctl(ctl), .subsys_clk_en(subsys_clk_en), .sram_start(sram_start), .sram_en(sram_en),
      .bp_start(bp_start), .bp_apply(bp_apply), .busy(busy), .done(done), .err(err),
      .dom_on(dom_on)
   );

   int checks = 0, failures = 0;
   bit finished = 1'b0;

   // fault knobs and responder latencies
   bit f_seclo = 0, f_both_hi = 0;
   bit sr_stk = 0, sr_stk_dir = 0, bp_stk = 0, bp_stk_dir = 0;
   int sr_lat = 2, bp_lat = 2;

   // power-switch acknowledge model: 4 cycles behind the switch bits
   logic [2:0] pp, ps;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pp <= '0; ps <= '0; ack_pri <= 1'b0; ack_sec <= 1'b0;
      end else begin
         pp <= {pp[1:0], ctl[2]};
         ps <= {ps[1:0], ctl[3]};
         ack_pri <= f_both_hi ? 1'b1 : pp[2];
         ack_sec <= f_both_hi ? 1'b1 : (f_seclo ? 1'b0 : ps[2]);
      end
   end

   // handshake responders
   int sr_cnt = 0, bp_cnt = 0;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_cnt <= 0; bp_cnt <= 0; sram_done <= 1'b0; bp_done <= 1'b0;
      end else begin
         sram_done <= 1'b0;
         bp_done   <= 1'b0;
         if (sram_start) begin
            if (!(sr_stk && sram_en == sr_stk_dir)) sr_cnt <= sr_lat;
         end else if (sr_cnt != 0) begin
            sr_cnt <= sr_cnt - 1;
            if (sr_cnt == 1) sram_done <= 1'b1;
         end
         if (bp_start) begin
            if (!(bp_stk && bp_apply == bp_stk_dir)) bp_cnt <= bp_lat;
         end else if (bp_cnt != 0) begin
            bp_cnt <= bp_cnt - 1;
            if (bp_cnt == 1) bp_done <= 1'b1;
         end
      end
   end

   // event monitor: code = kind*2+value; kinds 0..6 ctl bits, 7 subsys clk,
   // 8 sram start (value sram_en), 9 bus start (value bp_apply), 10 done (value err)
   int   log_q[$];
   int   exp_q[$];
   logic [7:0] prev = 8'h32;
   bit   seen_done = 1'b0;
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         for (int k = 0; k < 8; k++) begin
            if ({subsys_clk_en, ctl}[k] != prev[k]) log_q.push_back(k*2 + int'({subsys_clk_en, ctl}[k]));
         end
         prev = {subsys_clk_en, ctl};
         if (sram_start) log_q.push_back(16 + int'(sram_en));
         if (bp_start)   log_q.push_back(18 + int'(bp_apply));
         if (done) begin
            log_q.push_back(20 + int'(err));
            seen_done = 1'b1;
         end
      end else begin
         prev = 8'h32;
      end
   end

   // bench model of control state
   logic [7:0] m_ctl = 8'h32;
   bit m_up = 1'b0;
   bit m_imm, m_err;

   task automatic chk(bit ok, string tag, int act, int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic setb(int k, bit v);
      if (m_ctl[k] != v) begin
         exp_q.push_back(k*2 + int'(v));
         m_ctl[k] = v;
      end
   endtask

   task automatic fin(bit e);
      exp_q.push_back(20 + int'(e));
      m_err = e;
   endtask

   // reverse tail shared by power-down and unwind
   task automatic tail();
      setb(7, 0); m_up = 0;
      setb(1, 1); setb(4, 1); setb(0, 0); setb(3, 0); setb(2, 0);
   endtask

   // flt: 0 none, 1 acknowledge, 2 SRAM handshake, 3 bus handshake
   task automatic build_exp(bit on, bit s, bit c, int flt);
      exp_q.delete();
      m_imm = 0;
      if (on) begin
         if (m_up) begin m_imm = 1; fin(0); return; end
         setb(2, 1); setb(3, 1);
         if (flt == 1) begin tail(); fin(1); return; end
         setb(4, 0); setb(1, 0); setb(0, 1);
         if (!s) setb(7, 1);
         exp_q.push_back(17);
         if (flt == 2) begin tail(); fin(1); return; end
         if (c) begin setb(6, 1); setb(5, 0); end
         exp_q.push_back(18);
         if (flt == 3) begin
            exp_q.push_back(19);
            if (c) begin setb(5, 1); setb(6, 0); end
            exp_q.push_back(16);
            tail(); fin(1); return;
         end
         if (s) setb(7, 1);
         m_up = 1; fin(0);
      end else begin
         if (!m_up) begin m_imm = 1; fin(0); return; end
         exp_q.push_back(19);
         if (flt == 3) begin fin(1); return; end
         if (c) begin setb(5, 1); setb(6, 0); end
         exp_q.push_back(16);
         if (flt == 2) begin fin(1); return; end
         tail();
         fin(flt == 1);
      end
   endtask

   task automatic run_op(bit on, bit s, bit c, int flt, bit poke, string tag);
      int n;
      @(negedge clk);
      strict_mode = s; sram_iso_en = c;
      f_seclo   = on && flt == 1;
      f_both_hi = !on && flt == 1;
      sr_stk = (flt == 2); sr_stk_dir = on;
      bp_stk = (flt == 3); bp_stk_dir = !on;
      build_exp(on, s, c, flt);
      log_q.delete();
      seen_done = 0;
      if (on) on_req = 1; else off_req = 1;
      @(negedge clk);
      on_req = 0; off_req = 0;
      n = 0;
      while (!seen_done && n < 400) begin
         @(negedge clk);
         n++;
         if (poke && n == 6) begin on_req = 1; off_req = 1; end
         if (poke && n == 7) begin on_req = 0; off_req = 0; end
         if (on && flt == 1 && n == 12)
            chk(ack_pri && !ack_sec && !dom_on, {tag, " R2 single ack"}, int'(dom_on), 0);
      end
      chk(seen_done, {tag, " R7 operation completes"}, n, 400);
      if (m_imm) chk(n == 0, {tag, " R11 immediate done latency"}, n, 0);
      chk(err == m_err, {tag, " R7 err flag"}, int'(err), int'(m_err));
      @(negedge clk);
      chk(!done, {tag, " R12 done single cycle"}, int'(done), 0);
      f_seclo = 0; f_both_hi = 0; sr_stk = 0; bp_stk = 0;
      repeat (8) @(negedge clk);
      chk(!busy, {tag, " R10 idle after done"}, int'(busy), 0);
      checks++;
      if (log_q.size() != exp_q.size()) begin
         failures++;
         $display("FAIL %s sequence length actual=%0d expected=%0d", tag, log_q.size(), exp_q.size());
      end else begin
         for (int i = 0; i < log_q.size(); i++) begin
            if (log_q[i] != exp_q[i]) begin
               failures++;
               $display("FAIL %s event %0d actual=%0d expected=%0d", tag, i, log_q[i], exp_q[i]);
               break;
            end
         end
      end
   endtask

   initial begin
      int unsigned seed = $urandom(32'd4711);
      bit s, c, on;
      int flt;
      seed = seed + 1;
      repeat (3) @(negedge clk);
      chk(ctl == 7'h32 && !busy && !done && !err && !subsys_clk_en, "R1 reset state",
          int'(ctl), 32'h32);
      rst_n = 1;
      repeat (2) @(negedge clk);

      run_op(1, 0, 1, 0, 0, "R3 R4 R5 normal power-up");
      chk(dom_on, "R2 on after power-up", int'(dom_on), 1);
      run_op(1, 0, 1, 0, 0, "R11 repeat on");
      run_op(0, 0, 1, 0, 0, "R6 power-down");
      run_op(0, 0, 1, 0, 0, "R11 repeat off");
      run_op(1, 1, 0, 0, 1, "R5 R10 strict power-up with busy pokes");
      run_op(0, 1, 0, 3, 0, "R9 down bus timeout");
      run_op(1, 1, 0, 0, 0, "R9 R11 still counted on");
      run_op(0, 1, 0, 0, 0, "R6 retry power-down");
      run_op(1, 0, 1, 1, 0, "R7 R8 ack timeout unwind");
      run_op(1, 0, 1, 2, 0, "R8 SRAM timeout unwind");
      run_op(1, 1, 1, 3, 0, "R8 bus release timeout unwind");
      run_op(1, 0, 0, 3, 0, "R8 bus release timeout unwind normal");
      run_op(1, 0, 1, 0, 0, "R3 power-up after unwind");
      run_op(0, 0, 1, 1, 0, "R9 down ack timeout");
      run_op(1, 0, 1, 0, 0, "R9 counted off after ack timeout");
      run_op(0, 0, 1, 2, 0, "R9 down SRAM timeout");
      run_op(0, 0, 1, 0, 0, "R6 down after SRAM failure");

      for (int i = 0; i < 50; i++) begin
         on  = $urandom % 2;
         s   = $urandom % 2;
         c   = $urandom % 2;
         flt = ($urandom % 4 == 0) ? 1 + int'($urandom % 3) : 0;
         sr_lat = 1 + int'($urandom % 6);
         bp_lat = 1 + int'($urandom % 6);
         run_op(on, s, c, flt, ($urandom % 5 == 0), "R3 R6 R8 random");
      end

      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule